// File: doc/BRIEF.md
# Trip-Threshold Programming Command Sequencer

This block watches decoded two-wire bus events and recognizes two special write frames that reprogram a supply trip threshold code. A byte decoder upstream supplies pulses for START, STOP and each complete received byte (after its ACK slot). A separate input flag reports that a high programming voltage is present on the write-protect pin. A qualified frame is addressed to device byte A0h and carries a byte address and one data byte of 00h. Such a frame either loads the supply level presented at an input into the threshold register (byte address 01h) or forces the threshold register to its minimum code (byte address 03h).

The action is launched by the STOP that closes the frame. The block then holds a busy output until the programming flag is removed. A one-cycle claim pulse tells the memory write path that the closing STOP belongs to a threshold command, so the array is not written. Frames that do not match pass by unclaimed and leave the threshold untouched.

Top module: `trip_prog_seq`

## Requirements
- R1: After reset, thr_o equals DEF_CODE (20 by default), busy_o is 0 and claim_o is 0.
- R2: A frame is a candidate only if hv_i is 1 in the cycle its START pulse is seen. A frame started with hv_i at 0 causes no claim and no threshold change, even if hv_i rises later.
- R3: A command needs START, byte A0h, byte 01h or 03h, byte 00h, then STOP, with hv_i still 1 at STOP. Any other device byte, byte address or data byte, or an extra data byte before STOP, leaves thr_o unchanged and gives no claim.
- R4: Byte address 01h (set) loads level_i into thr_o only when level_i is greater than thr_o. Otherwise thr_o keeps its value. Lowering therefore takes a reset followed by a set.
- R5: Byte address 03h (reset) forces thr_o to MIN_CODE (4 by default).
- R6: For a valid command, busy_o rises and thr_o takes its new value in the cycle after the STOP pulse.
- R7: busy_o stays 1 while hv_i is 1 and clears in the cycle after hv_i is seen low. Bus events during busy are ignored.
- R8: claim_o is a single-cycle pulse, coincident with the rise of busy_o, and only for valid commands. Ordinary frames never claim.
- R9: A START in mid-frame restarts recognition, qualified by hv_i at that START. A STOP in mid-frame aborts, and later bytes until the next START are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START condition seen (one-cycle pulse) |
| stop_i | input | 1 | STOP condition seen (one-cycle pulse) |
| byte_vld_i | input | 1 | Complete byte received and acknowledged (one-cycle pulse) |
| byte_i | input | 8 | Received byte, valid with byte_vld_i |
| hv_i | input | 1 | Programming voltage present on write-protect pin |
| level_i | input | LVL_W | Digitized present supply level |
| busy_o | output | 1 | Threshold programming in progress |
| claim_o | output | 1 | Pulse: the closing STOP belongs to a threshold command |
| thr_o | output | LVL_W | Stored trip threshold code |

## Verification
Every byte address value is swept inside an otherwise valid frame, which separates the two command codes from all 254 ordinary addresses. Sweeps of every data byte and every device byte then show that only 00h and A0h qualify. The supply level moves between frames, so a set that raises the code is told apart from one that would lower it. Directed frames cover the remaining cases: late programming voltage, voltage removed before STOP, an extra page byte, a mid-frame STOP, a mid-frame restart and a command sent while busy. Each shows whether the sequencer returns to idle without touching the threshold.

// File: rtl/trip_prog_pkg.sv
package trip_prog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_DATA,
    ST_FULL,
    ST_BUSY
  } seq_state_e;

  typedef enum logic {
    OP_SET,
    OP_RST
  } thr_op_e;
endpackage

// File: rtl/trip_frame_fsm.sv
module trip_frame_fsm
  import trip_prog_pkg::*;
#(
  parameter logic [7:0] DEV_BYTE = 8'hA0,
  parameter logic [7:0] SET_ADDR = 8'h01,
  parameter logic [7:0] RST_ADDR = 8'h03,
  parameter logic [7:0] KEY_DATA = 8'h00
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    stop_i,
  input  logic    byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic    hv_i,
  output logic    fire_o,
  output thr_op_e op_o,
  output logic    busy_o,
  output logic    claim_o
);
  seq_state_e state_q, state_d;
  thr_op_e    op_q, op_d;
  logic       claim_q;

  assign fire_o = (state_q == ST_FULL) && stop_i && hv_i;

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    if (state_q == ST_BUSY) begin
      if (!hv_i) state_d = ST_IDLE;
    end else if (start_i) begin
      state_d = hv_i ? ST_DEV : ST_IDLE;
    end else if (stop_i) begin
      state_d = fire_o ? ST_BUSY : ST_IDLE;
    end else if (byte_vld_i) begin
      unique case (state_q)
        ST_DEV:  state_d = (byte_i == DEV_BYTE) ? ST_ADDR : ST_IDLE;
        ST_ADDR: begin
          if (byte_i == SET_ADDR) begin
            state_d = ST_DATA;
            op_d    = OP_SET;
          end else if (byte_i == RST_ADDR) begin
            state_d = ST_DATA;
            op_d    = OP_RST;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_DATA: state_d = (byte_i == KEY_DATA) ? ST_FULL : ST_IDLE;
        default: state_d = ST_IDLE; // extra page byte or idle traffic
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_SET;
      claim_q <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      claim_q <= fire_o;
    end
  end

  assign op_o    = op_q;
  assign busy_o  = (state_q == ST_BUSY);
  assign claim_o = claim_q;

  p_one_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_i, stop_i, byte_vld_i}));
  p_busy_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !hv_i) |=> !busy_o);
  p_busy_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && hv_i) |=> busy_o);
  p_busy_launch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i && hv_i));
  p_claim_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |=> !claim_o);
  p_claim_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> $rose(busy_o));
endmodule

// File: rtl/trip_thr_reg.sv
module trip_thr_reg
  import trip_prog_pkg::*;
#(
  parameter int unsigned LVL_W    = 6,
  parameter int unsigned MIN_CODE = 4,
  parameter int unsigned DEF_CODE = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  thr_op_e          op_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [LVL_W-1:0] thr_o
);
  localparam logic [LVL_W-1:0] MinVal = LVL_W'(MIN_CODE);
  localparam logic [LVL_W-1:0] DefVal = LVL_W'(DEF_CODE);

  logic [LVL_W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= DefVal;
    end else if (fire_i) begin
      if (op_i == OP_RST)          thr_q <= MinVal;
      else if (level_i > thr_q)    thr_q <= level_i; // set only raises
    end
  end

  assign thr_o = thr_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(thr_q));
  p_set_raise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && op_i == OP_SET) |=> (thr_q >= $past(thr_q)));
  p_reset_min_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && op_i == OP_RST) |=> (thr_q == MinVal));
endmodule

// File: rtl/trip_prog_seq.sv
module trip_prog_seq
  import trip_prog_pkg::*;
#(
  parameter int unsigned LVL_W    = 6,
  parameter int unsigned MIN_CODE = 4,
  parameter int unsigned DEF_CODE = 20,
  parameter logic [7:0]  DEV_BYTE = 8'hA0,
  parameter logic [7:0]  SET_ADDR = 8'h01,
  parameter logic [7:0]  RST_ADDR = 8'h03,
  parameter logic [7:0]  KEY_DATA = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             hv_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             busy_o,
  output logic             claim_o,
  output logic [LVL_W-1:0] thr_o
);
  logic    fire;
  thr_op_e op;

  trip_frame_fsm #(
    .DEV_BYTE(DEV_BYTE),
    .SET_ADDR(SET_ADDR),
    .RST_ADDR(RST_ADDR),
    .KEY_DATA(KEY_DATA)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .byte_vld_i(byte_vld_i),
    .byte_i    (byte_i),
    .hv_i      (hv_i),
    .fire_o    (fire),
    .op_o      (op),
    .busy_o    (busy_o),
    .claim_o   (claim_o)
  );

  trip_thr_reg #(
    .LVL_W   (LVL_W),
    .MIN_CODE(MIN_CODE),
    .DEF_CODE(DEF_CODE)
  ) u_thr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .op_i   (op),
    .level_i(level_i),
    .thr_o  (thr_o)
  );
endmodule

// File: tb/trip_prog_seq_tb_top.sv
`timescale 1ns/1ps
module trip_prog_seq_tb_top;
  localparam int LVL_W = 6;
  localparam int MINC  = 4;
  localparam int DEFC  = 20;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0]       byte_i = 8'h00;
  logic             hv_i = 1'b0;
  logic [LVL_W-1:0] level_i = '0;
  logic             busy_o, claim_o;
  logic [LVL_W-1:0] thr_o;

  int checks = 0, failures = 0, cyc = 0, exp_thr = DEFC;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  trip_prog_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .hv_i(hv_i), .level_i(level_i),
    .busy_o(busy_o), .claim_o(claim_o), .thr_o(thr_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ev_start();
    @(negedge clk_i); start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
  endtask
  task automatic ev_stop();
    @(negedge clk_i); stop_i = 1'b1; @(negedge clk_i); stop_i = 1'b0;
  endtask
  task automatic ev_byte(input logic [7:0] b);
    @(negedge clk_i); byte_i = b; byte_vld_i = 1'b1; @(negedge clk_i); byte_vld_i = 1'b0;
  endtask

  // sampled at the negedge right after the STOP posedge
  task automatic expect_out(input bit cl, input bit bz, input string req);
    chk(claim_o == cl, {req, " claim"}, int'(claim_o), int'(cl));
    chk(busy_o == bz, {req, " busy"}, int'(busy_o), int'(bz));
    chk(int'(thr_o) == exp_thr, {req, " thr"}, int'(thr_o), exp_thr);
  endtask

  task automatic release_hv(input string req);
    hv_i = 1'b0;
    @(negedge clk_i);
    chk(busy_o == 1'b0, {req, " busy clear"}, int'(busy_o), 0);
    chk(claim_o == 1'b0, {req, " claim low"}, int'(claim_o), 0);
  endtask

  // full three-byte frame under hv, bench model decides the outcome
  task automatic frame(input logic [7:0] dv, input logic [7:0] ad,
                       input logic [7:0] dt, input string req);
    bit sp;
    hv_i = 1'b1;
    ev_start(); ev_byte(dv); ev_byte(ad); ev_byte(dt); ev_stop();
    sp = (dv == 8'hA0) && (dt == 8'h00) && (ad == 8'h01 || ad == 8'h03);
    if (sp && ad == 8'h03) exp_thr = MINC;
    else if (sp && int'(level_i) > exp_thr) exp_thr = int'(level_i);
    expect_out(sp, sp, req);
    release_hv(req);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(int'(thr_o) == DEFC, "R1 thr", int'(thr_o), DEFC);
    chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
    chk(claim_o == 1'b0, "R1 claim", int'(claim_o), 0);

    // R4 R5 R8: byte address sweep with a moving supply level
    for (int a = 0; a < 256; a++) begin
      level_i = LVL_W'((a * 7 + 9) % 64);
      frame(8'hA0, 8'(a), 8'h00, "R3 R4 R5 addr sweep");
    end
    // R3: data byte sweep (set command)
    for (int d = 0; d < 256; d++) begin
      level_i = LVL_W'((d * 5 + 3) % 64);
      frame(8'hA0, 8'h01, 8'(d), "R3 data sweep");
    end
    // R3: device byte sweep (reset command)
    for (int v = 0; v < 256; v++) begin
      frame(8'(v), 8'h03, 8'h00, "R3 R5 dev sweep");
      level_i = LVL_W'((v * 11 + 1) % 64);
      frame(8'hA0, 8'h01, 8'h00, "R4 set after dev");
    end

    // R4 lowering: set with a lower level does nothing, reset then set does
    level_i = 6'd50; frame(8'hA0, 8'h01, 8'h00, "R4 raise");
    level_i = 6'd30; frame(8'hA0, 8'h01, 8'h00, "R4 no lower");
    frame(8'hA0, 8'h03, 8'h00, "R5 reset");
    frame(8'hA0, 8'h01, 8'h00, "R4 set after reset");
    chk(int'(thr_o) == 30, "R4 lowered value", int'(thr_o), 30);

    // R2: hv raised after START
    level_i = 6'd60;
    hv_i = 1'b0; ev_start(); hv_i = 1'b1;
    ev_byte(8'hA0); ev_byte(8'h01); ev_byte(8'h00); ev_stop();
    expect_out(1'b0, 1'b0, "R2 late hv");
    hv_i = 1'b0; @(negedge clk_i);

    // R3: hv removed before STOP
    hv_i = 1'b1; ev_start(); ev_byte(8'hA0); ev_byte(8'h01); ev_byte(8'h00);
    hv_i = 1'b0; ev_stop();
    expect_out(1'b0, 1'b0, "R3 hv gone at stop");

    // R3: extra page byte
    frame(8'hA0, 8'h01, 8'h00, "R3 setup"); // raises to 60
    level_i = 6'd62;
    hv_i = 1'b1; ev_start(); ev_byte(8'hA0); ev_byte(8'h01); ev_byte(8'h00);
    ev_byte(8'h00); ev_stop();
    expect_out(1'b0, 1'b0, "R3 extra byte");
    hv_i = 1'b0; @(negedge clk_i);

    // R9: mid-frame STOP then stray bytes
    hv_i = 1'b1; ev_start(); ev_byte(8'hA0); ev_byte(8'h03); ev_stop();
    expect_out(1'b0, 1'b0, "R9 mid stop");
    ev_byte(8'h00); ev_stop();
    expect_out(1'b0, 1'b0, "R9 stray after abort");

    // R9: mid-frame restart
    ev_start(); ev_byte(8'hA0);
    ev_start(); ev_byte(8'hA0); ev_byte(8'h03); ev_byte(8'h00); ev_stop();
    exp_thr = MINC;
    expect_out(1'b1, 1'b1, "R9 restart R6");

    // R7: command while busy ignored, busy holds
    @(negedge clk_i);
    chk(claim_o == 1'b0, "R8 single pulse", int'(claim_o), 0);
    ev_start(); ev_byte(8'hA0); ev_byte(8'h01); ev_byte(8'h00); ev_stop();
    expect_out(1'b0, 1'b1, "R7 busy ignores");
    release_hv("R7 release");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule